// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block sequences one thread of an out-of-order rename stage. Decoded instructions arrive in groups of up to `W` per cycle. Every arriving instruction is written into a small skid queue. Each cycle the controller takes the oldest queued instructions, up to `W` of them, and forwards them to the back end, stopping early when a rule forbids it. Register mapping itself happens elsewhere: the block only decides how many instructions go, which ones, and why the rest wait.

The back end supplies three inputs: the free-entry counts of the reorder buffer, the issue queue and the load/store queue, and an acknowledge count for instructions that those counts now include. The controller keeps its own count of instructions that have been forwarded but not yet acknowledged, and subtracts it from every free count. Later stages can request a stall. A squash flushes the thread. Serializing instructions wait until the back end is empty, and a "serialize-after" marker turns the next instruction into a serializing one.

The outputs are all registered: the forwarded count and tags, a hold signal back to decode, the code of the structure that is full, and the thread phase.

Top module: `rename_flow_ctl`

## Requirements
- R1: After reset, phase is Idle (1), out_cnt is 0, out_tag is 0, hold is 0 and full_src is NONE (3).
- R2: Instructions leave in arrival order, at most W per cycle. An instruction presented in cycle t first appears on out_tag after the second rising edge that follows. Unused out_tag slots read 0.
- R3: hold is asserted after an edge at which the queue holds more than D-W entries. While hold is high, decode sends nothing, and no accepted instruction is ever lost.
- R4: The forwarded group is cut at the first instruction for which the room is short. The room is checked in this priority order: reorder buffer (each instruction needs one entry), then issue queue (one entry each), then load/store queue (memory instructions only). When a group is cut this way, full_src reports the cause as ROB=0, IQ=1 or LSQ=2, and phase becomes Blocked (4). Otherwise full_src is NONE=3.
- R5: The usable room in each structure is its free count minus the in-flight count, floored at 0. The in-flight count rises by the number forwarded and falls by ack_cnt.
- R6: A serialize-before instruction at the head of the queue is forwarded alone, and only when rob_empty is 1 and the in-flight count is 0. Until then the phase is SerializeStall (6). A serializing instruction that is not at the head ends the group in front of it.
- R7: An instruction marked serialize-after is the last one in its group, and the next instruction is treated as serialize-before.
- R8: If stall_exe or stall_cmt is high, and no squash is under way, nothing is forwarded and the phase becomes Blocked.
- R9: squash flushes the queue, the current input, the in-flight count and the serialize-after flag. The phase then runs StartSquash (2), Squashing (3) and Running (0), and input is dropped during the first two of those phases.
- R10: A phase of Blocked, Unblocking or SerializeStall that is now free to forward becomes Running (0) once every older queued entry has been forwarded, and Unblocking (5) while some remain. From any other phase, the next phase is Idle when the queue ends the cycle empty and Running when it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cnt | input | NW | Number of valid incoming instructions (slots 0..in_cnt-1) |
| in_tag | input | W*TAG_W | Tags of incoming instructions, slot k at bits k*TAG_W |
| in_ser | input | W | Serialize-before flag per slot |
| in_sera | input | W | Serialize-after flag per slot |
| in_mem | input | W | Memory-instruction flag per slot (needs a load/store entry) |
| free_rob | input | CW | Free reorder buffer entries |
| free_iq | input | CW | Free issue queue entries |
| free_lsq | input | CW | Free load/store queue entries |
| rob_empty | input | 1 | Reorder buffer is empty |
| ack_cnt | input | NW | Forwarded instructions now counted by the back end |
| stall_exe | input | 1 | Stall request from execute |
| stall_cmt | input | 1 | Stall request from commit |
| squash | input | 1 | Flush this thread |
| out_cnt | output | NW | Number of instructions forwarded |
| out_tag | output | W*TAG_W | Forwarded tags, oldest in slot 0 |
| hold | output | 1 | Decode must not send next cycle |
| full_src | output | 2 | Cause of a capacity cut: 0 ROB, 1 IQ, 2 LSQ, 3 none |
| phase | output | 3 | Thread phase code |

## Verification
A corrupted queue pointer or occupancy shows at the ports within one or two cycles, as a wrong, repeated or missing tag on out_tag or as hold changing at the wrong edge. An in-flight count that has drifted appears as a capacity cut with the wrong cause in full_src, or as a serializing instruction that is released too early or held too long, which also shows in phase. A wrong phase is visible directly on the phase output one edge after the cause. The squash sequence is checked over its three visible phases, and the queue must be empty afterwards.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int TAG_W = 6;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             ser_bef;
    logic             ser_aft;
    logic             mem;
  } slot_t;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_SQ0   = 3'd2,
    ST_SQ1   = 3'd3,
    ST_BLK   = 3'd4,
    ST_UNBLK = 3'd5,
    ST_SER   = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    FS_ROB  = 2'd0,
    FS_IQ   = 2'd1,
    FS_LSQ  = 2'd2,
    FS_NONE = 2'd3
  } fsrc_e;
endpackage

// File: rtl/rn_skid.sv
module rn_skid
  import rn_pkg::*;
#(
  parameter int W = 2,
  parameter int D = 8,
  localparam int PW = $clog2(D),
  localparam int OW = $clog2(D + 1),
  localparam int NW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [NW-1:0] push_n,
  input  slot_t         push_d [W],
  input  logic [NW-1:0] pop_n,
  output slot_t         head   [W],
  output logic [OW-1:0] occ
);
  slot_t         mem_q [D];
  logic [PW-1:0] rd_q, wr_q;
  logic [OW-1:0] occ_q;

  always_ff @(posedge clk) begin
    for (int j = 0; j < W; j++) begin
      if (NW'(j) < push_n) mem_q[wr_q + PW'(j)] <= push_d[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= '0;
    end else begin
      wr_q  <= wr_q + PW'(push_n);
      rd_q  <= rd_q + PW'(pop_n);
      occ_q <= occ_q + OW'(push_n) - OW'(pop_n);
    end
  end

  generate
    for (genvar k = 0; k < W; k++) begin : g_head
      assign head[k] = mem_q[rd_q + PW'(k)];
    end
  endgenerate

  assign occ = occ_q;

  AST_SKID_ROOM: assert property (@(posedge clk) disable iff (rst || flush)
    (int'(occ_q) + int'(push_n) - int'(pop_n) <= D)); // R3
  AST_POP_HELD: assert property (@(posedge clk) disable iff (rst || flush)
    (OW'(pop_n) <= occ_q)); // R2
endmodule

// File: rtl/rn_admit.sv
module rn_admit
  import rn_pkg::*;
#(
  parameter int W  = 2,
  parameter int D  = 8,
  parameter int CW = 6,
  localparam int OW = $clog2(D + 1),
  localparam int NW = $clog2(W + 1)
) (
  input  slot_t         head [W],
  input  logic [OW-1:0] occ,
  input  logic          ser_next,
  input  logic          rob_empty,
  input  logic [CW-1:0] inflight,
  input  logic [CW-1:0] free_rob,
  input  logic [CW-1:0] free_iq,
  input  logic [CW-1:0] free_lsq,
  input  logic          stall,
  output logic [NW-1:0] take_n,
  output fsrc_e         src,
  output logic          ser_wait,
  output logic          cap_blk
);
  logic [CW-1:0] rob_av, iq_av, lsq_av, mcnt;
  logic          stop, is_ser;

  always_comb begin
    rob_av   = (free_rob > inflight) ? free_rob - inflight : '0;
    iq_av    = (free_iq  > inflight) ? free_iq  - inflight : '0;
    lsq_av   = (free_lsq > inflight) ? free_lsq - inflight : '0;
    take_n   = '0;
    src      = FS_NONE;
    ser_wait = 1'b0;
    cap_blk  = 1'b0;
    stop     = stall;
    mcnt     = '0;
    is_ser   = 1'b0;
    for (int k = 0; k < W; k++) begin
      is_ser = head[k].ser_bef || ((k == 0) && ser_next);
      if (!stop && (OW'(k) < occ)) begin
        if (is_ser && (k != 0)) begin
          stop = 1'b1;
        end else if (is_ser && !(rob_empty && (inflight == '0))) begin
          stop = 1'b1; ser_wait = 1'b1;
        end else if (CW'(k + 1) > rob_av) begin
          stop = 1'b1; cap_blk = 1'b1; src = FS_ROB;
        end else if (CW'(k + 1) > iq_av) begin
          stop = 1'b1; cap_blk = 1'b1; src = FS_IQ;
        end else if (mcnt + CW'(head[k].mem) > lsq_av) begin
          stop = 1'b1; cap_blk = 1'b1; src = FS_LSQ;
        end else begin
          take_n = NW'(k + 1);
          mcnt   = mcnt + CW'(head[k].mem);
          if (is_ser || head[k].ser_aft) stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rename_flow_ctl.sv
module rename_flow_ctl
  import rn_pkg::*;
#(
  parameter int W  = 2,
  parameter int D  = 8,
  parameter int CW = 6,
  localparam int NW = $clog2(W + 1),
  localparam int OW = $clog2(D + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NW-1:0]   in_cnt,
  input  logic [W*TAG_W-1:0] in_tag,
  input  logic [W-1:0]    in_ser,
  input  logic [W-1:0]    in_sera,
  input  logic [W-1:0]    in_mem,
  input  logic [CW-1:0]   free_rob,
  input  logic [CW-1:0]   free_iq,
  input  logic [CW-1:0]   free_lsq,
  input  logic            rob_empty,
  input  logic [NW-1:0]   ack_cnt,
  input  logic            stall_exe,
  input  logic            stall_cmt,
  input  logic            squash,
  output logic [NW-1:0]   out_cnt,
  output logic [W*TAG_W-1:0] out_tag,
  output logic            hold,
  output logic [1:0]      full_src,
  output logic [2:0]      phase
);
  phase_e        ph_q, ph_d;
  fsrc_e         fs_q, src;
  logic [CW-1:0] infl_q, infl_d;
  logic          sn_q, sn_d;
  logic [NW-1:0] cnt_q, push_n, pop_n, take_n;
  logic [W*TAG_W-1:0] tag_q;
  logic          hold_q, sq_mode, stall, ser_wait, cap_blk;
  logic [OW-1:0] occ, rem, new_occ;
  slot_t         in_slot [W];
  slot_t         head    [W];

  generate
    for (genvar k = 0; k < W; k++) begin : g_in
      assign in_slot[k] = '{tag: in_tag[k*TAG_W +: TAG_W], ser_bef: in_ser[k],
                            ser_aft: in_sera[k], mem: in_mem[k]};
    end
  endgenerate

  assign sq_mode = (ph_q == ST_SQ0) || (ph_q == ST_SQ1);
  assign stall   = stall_exe || stall_cmt;
  assign push_n  = (squash || sq_mode) ? '0 : in_cnt;
  assign pop_n   = (squash || sq_mode) ? '0 : take_n;

  rn_skid #(.W(W), .D(D)) u_skid (
    .clk(clk), .rst(rst), .flush(squash), .push_n(push_n), .push_d(in_slot),
    .pop_n(pop_n), .head(head), .occ(occ));

  rn_admit #(.W(W), .D(D), .CW(CW)) u_admit (
    .head(head), .occ(occ), .ser_next(sn_q), .rob_empty(rob_empty), .inflight(infl_q),
    .free_rob(free_rob), .free_iq(free_iq), .free_lsq(free_lsq), .stall(stall),
    .take_n(take_n), .src(src), .ser_wait(ser_wait), .cap_blk(cap_blk));

  always_comb begin
    rem     = occ - OW'(pop_n);
    new_occ = squash ? '0 : rem + OW'(push_n);
    infl_d  = infl_q;
    sn_d    = sn_q;
    if (squash) begin
      infl_d = '0;
      sn_d   = 1'b0;
    end else if (!sq_mode) begin
      infl_d = infl_q + CW'(pop_n) - CW'(ack_cnt);
      if (pop_n != '0) sn_d = head[pop_n - 1'b1].ser_aft;
    end
    if (squash)                 ph_d = ST_SQ0;
    else if (ph_q == ST_SQ0)    ph_d = ST_SQ1;
    else if (ph_q == ST_SQ1)    ph_d = ST_RUN;
    else if (stall)             ph_d = ST_BLK;
    else if (ser_wait)          ph_d = ST_SER;
    else if (cap_blk)           ph_d = ST_BLK;
    else if (ph_q inside {ST_BLK, ST_UNBLK, ST_SER})
                                ph_d = (rem == '0) ? ST_RUN : ST_UNBLK;
    else                        ph_d = (new_occ == '0) ? ST_IDLE : ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= ST_IDLE;
      fs_q   <= FS_NONE;
      infl_q <= '0;
      sn_q   <= 1'b0;
      cnt_q  <= '0;
      tag_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      fs_q   <= (squash || sq_mode) ? FS_NONE : src;
      infl_q <= infl_d;
      sn_q   <= sn_d;
      cnt_q  <= pop_n;
      hold_q <= new_occ > OW'(D - W);
      for (int k = 0; k < W; k++)
        tag_q[k*TAG_W +: TAG_W] <= (NW'(k) < pop_n) ? head[k].tag : '0;
    end
  end

  assign out_cnt  = cnt_q;
  assign out_tag  = tag_q;
  assign hold     = hold_q;
  assign full_src = fs_q;
  assign phase    = ph_q;

  AST_ACK_BOUND: assert property (@(posedge clk) disable iff (rst)
    (ack_cnt <= NW'(W)) && (CW'(ack_cnt) <= infl_q)); // R5
  AST_SQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (ph_q == ST_SQ0) && !squash |=> (ph_q == ST_SQ1)); // R9
  AST_SQ_EXIT: assert property (@(posedge clk) disable iff (rst)
    (ph_q == ST_SQ1) && !squash |=> (ph_q == ST_RUN)); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    stall && !squash && !sq_mode |=> (cnt_q == '0) && (ph_q == ST_BLK)); // R8
  AST_SER_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ph_q == ST_SER) |-> (cnt_q == '0)); // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (fs_q != FS_NONE) |-> (ph_q == ST_BLK)); // R4
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ph_q == ST_IDLE) |-> (occ == '0)); // R10
  AST_HOLD_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    hold_q && !squash && !sq_mode |-> (in_cnt == '0)); // R3
endmodule

// File: tb/sim_rename_flow_ctl.sv
module sim_rename_flow_ctl;
  import rn_pkg::*;
  localparam int W = 2, D = 8, CW = 6, NW = 2;
  localparam time TCK = 10;

  logic clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic rst;
  logic [NW-1:0] in_cnt, ack_cnt, out_cnt;
  logic [W*TAG_W-1:0] in_tag, out_tag;
  logic [W-1:0] in_ser, in_sera, in_mem;
  logic [CW-1:0] free_rob, free_iq, free_lsq;
  logic rob_empty, stall_exe, stall_cmt, squash, hold;
  logic [1:0] full_src;
  logic [2:0] phase;

  rename_flow_ctl #(.W(W), .D(D), .CW(CW)) u0 (.*);

  slot_t mq[$];
  int m_infl, m_ph, n_cmp, n_bad, tg;
  bit m_sn, m_blk;

  task automatic chk(string rq, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic set_in(int cnt, bit s0, bit a0, bit m0, bit s1, bit a1, bit m1);
    in_cnt = NW'(cnt);
    for (int j = 0; j < W; j++) begin
      in_tag[j*TAG_W +: TAG_W] = TAG_W'(tg + j);
    end
    tg = tg + cnt;
    in_ser = {s1, s0}; in_sera = {a1, a0}; in_mem = {m1, m0};
  endtask

  task automatic cycle(string rq);
    int n = 0, src = 3, mc = 0, rav, iav, lav, eph, rem;
    bit serw = 0, capb = 0, stop, s;
    int etag[W];
    bit stl;
    if (m_blk) in_cnt = '0;
    if (int'(ack_cnt) > m_infl) ack_cnt = NW'(m_infl);
    #0;
    stl = stall_exe | stall_cmt;
    for (int k = 0; k < W; k++) etag[k] = 0;
    if (squash) begin
      mq.delete(); m_infl = 0; m_sn = 0; eph = 2;
    end else if (m_ph == 2 || m_ph == 3) begin
      eph = (m_ph == 2) ? 3 : 0;
    end else begin
      rav = (free_rob > m_infl) ? free_rob - m_infl : 0;
      iav = (free_iq  > m_infl) ? free_iq  - m_infl : 0;
      lav = (free_lsq > m_infl) ? free_lsq - m_infl : 0;
      stop = stl;
      for (int k = 0; k < W; k++) begin
        if (!stop && k < mq.size()) begin
          s = mq[k].ser_bef || (k == 0 && m_sn);
          if (s && k != 0) stop = 1;
          else if (s && !(rob_empty && m_infl == 0)) begin stop = 1; serw = 1; end
          else if (k + 1 > rav) begin stop = 1; capb = 1; src = 0; end
          else if (k + 1 > iav) begin stop = 1; capb = 1; src = 1; end
          else if (mc + int'(mq[k].mem) > lav) begin stop = 1; capb = 1; src = 2; end
          else begin
            n = k + 1; mc += int'(mq[k].mem);
            if (s || mq[k].ser_aft) stop = 1;
          end
        end
      end
      for (int k = 0; k < n; k++) etag[k] = int'(mq[k].tag);
      if (n > 0) m_sn = mq[n-1].ser_aft;
      m_infl = m_infl + n - int'(ack_cnt);
      for (int k = 0; k < n; k++) void'(mq.pop_front());
      rem = mq.size();
      for (int j = 0; j < int'(in_cnt); j++)
        mq.push_back('{tag: in_tag[j*TAG_W +: TAG_W], ser_bef: in_ser[j],
                       ser_aft: in_sera[j], mem: in_mem[j]});
      if (stl) eph = 4;
      else if (serw) eph = 6;
      else if (capb) eph = 4;
      else if (m_ph == 4 || m_ph == 5 || m_ph == 6) eph = (rem == 0) ? 0 : 5;
      else eph = (mq.size() == 0) ? 1 : 0;
    end
    m_blk = mq.size() > D - W;
    m_ph = eph;
    @(posedge clk); #1;
    chk("R2", "out_cnt", int'(out_cnt), n);
    for (int k = 0; k < W; k++) chk("R2", "out_tag", int'(out_tag[k*TAG_W +: TAG_W]), etag[k]);
    chk("R3", "hold", int'(hold), int'(m_blk));
    chk(rq, "full_src", int'(full_src), src);
    chk(rq, "phase", int'(phase), eph);
    set_in(0, 0, 0, 0, 0, 0, 0);
    ack_cnt = '0; squash = 0; stall_exe = 0; stall_cmt = 0;
  endtask

  task automatic res(int r, int i, int l, bit e);
    free_rob = CW'(r); free_iq = CW'(i); free_lsq = CW'(l); rob_empty = e;
  endtask

  initial begin
    #(TCK * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    n_cmp = 0; n_bad = 0; tg = 1; m_infl = 0; m_ph = 1; m_sn = 0; m_blk = 0;
    rst = 1; squash = 0; stall_exe = 0; stall_cmt = 0; ack_cnt = '0;
    set_in(0, 0, 0, 0, 0, 0, 0); res(40, 40, 40, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "phase", int'(phase), 1);
    chk("R1", "out_cnt", int'(out_cnt), 0);
    chk("R1", "out_tag", int'(out_tag), 0);
    chk("R1", "hold", int'(hold), 0);
    chk("R1", "full_src", int'(full_src), 3);
    rst = 0;

    // R2: streaming with ample room
    for (int i = 0; i < 6; i++) begin set_in(2, 0, 0, 1, 0, 0, 0); ack_cnt = 2; cycle("R2"); end
    ack_cnt = 2; cycle("R10"); ack_cnt = 2; cycle("R10"); ack_cnt = 2; cycle("R10");
    // R8 and R3: stall fills the queue until hold
    for (int i = 0; i < 6; i++) begin set_in(2, 0, 0, 0, 0, 0, 0); stall_cmt = (i % 2 == 1); stall_exe = (i % 2 == 0); cycle("R8"); end
    for (int i = 0; i < 6; i++) begin ack_cnt = 2; cycle("R10"); end
    // R4: each structure as the cause
    res(1, 40, 40, 0); set_in(2, 0, 0, 0, 0, 0, 0); ack_cnt = 2; cycle("R4"); cycle("R4");
    res(40, 1, 40, 0); ack_cnt = 2; cycle("R4"); cycle("R4");
    res(40, 40, 0, 0); set_in(2, 0, 0, 1, 0, 0, 1); ack_cnt = 2; cycle("R4"); cycle("R4");
    res(40, 40, 40, 0); ack_cnt = 2; cycle("R4"); ack_cnt = 2; cycle("R4"); ack_cnt = 2; cycle("R4");
    // R5: in-flight count eats into the room
    res(3, 40, 40, 0);
    for (int i = 0; i < 5; i++) begin set_in(2, 0, 0, 0, 0, 0, 0); cycle("R5"); end
    for (int i = 0; i < 4; i++) begin ack_cnt = 2; cycle("R5"); end
    // R6: serialize-before waits for empty back end
    res(40, 40, 40, 0); set_in(2, 1, 0, 0, 0, 0, 0); cycle("R6");
    cycle("R6"); cycle("R6");
    res(40, 40, 40, 1); cycle("R6"); ack_cnt = 2; cycle("R6"); cycle("R6"); cycle("R6");
    set_in(2, 0, 0, 0, 1, 0, 0); cycle("R6"); cycle("R6"); ack_cnt = 2; cycle("R6"); cycle("R6");
    // R7: serialize-after
    res(40, 40, 40, 0); set_in(2, 0, 1, 0, 0, 0, 0); cycle("R7"); cycle("R7"); cycle("R7");
    res(40, 40, 40, 1); ack_cnt = 2; cycle("R7"); ack_cnt = 2; cycle("R7"); cycle("R7");
    // R9: squash with queued work
    res(0, 40, 40, 0); for (int i = 0; i < 3; i++) begin set_in(2, 0, 0, 0, 0, 0, 0); cycle("R9"); end
    squash = 1; set_in(2, 0, 0, 0, 0, 0, 0); cycle("R9");
    set_in(2, 0, 0, 0, 0, 0, 0); cycle("R9"); set_in(1, 0, 0, 0, 0, 0, 0); cycle("R9");
    res(40, 40, 40, 0); cycle("R9"); cycle("R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      set_in($urandom_range(0, W),
             ($urandom_range(0, 11) == 0), ($urandom_range(0, 11) == 0), ($urandom_range(0, 2) == 0),
             ($urandom_range(0, 11) == 0), ($urandom_range(0, 11) == 0), ($urandom_range(0, 2) == 0));
      res($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 10), ($urandom_range(0, 1) == 1));
      ack_cnt   = NW'($urandom_range(0, W));
      stall_exe = ($urandom_range(0, 11) == 0);
      stall_cmt = ($urandom_range(0, 11) == 0);
      squash    = ($urandom_range(0, 49) == 0);
      cycle("R10");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule